// File: doc/BRIEF.md
# Processor Register Bank with Banked Stack Pointer

This block is the architectural register store of a small 32-bit load-store core. It keeps thirteen general-purpose registers, two physical stack pointers that share index 13, a link register at index 14 and the program counter at index 15. It also holds the four ALU condition flags, an interrupt-mask bit and a stack-select control bit. The core's decode, ALU, memory and exception logic sit outside; they drive results into this block and read operands out of it.

Two combinational read ports return any of the sixteen indices, with same-cycle bypass from the single write port. A sequencing input advances the PC by 2 or 4, branches, calls (saving the return address in the link register on the same edge) or returns (reloading the PC from the link register). The stack-select control runs a two-state machine: `STK_MAIN` (index 13 reaches the main stack pointer) and `STK_PROC` (index 13 reaches the process stack pointer). The transition `STK_MAIN -> STK_PROC` is taken on a control write with bit 0 set. The transition `STK_PROC -> STK_MAIN` is taken on a control write with bit 0 clear. Every other cycle holds the state. The mask bit gates a request vector so that only the two non-maskable lines pass while it is set.

Top module: `cpu_regbank`

## Requirements
- R1: While `rst_n` is low, and after it rises, R0..R12, the process stack pointer, the link register, the flags, the mask bit and the stack-select state are all zero. The main stack pointer holds `msp_rst_val`. The PC holds `pc_rst_val` with bit 0 cleared.
- R2: A write (`wr_en`=1) to index 0..14 takes effect at the next rising edge. Both read ports return the register picked by their index combinationally. Index 15 reads the PC. A write to index 15 is ignored.
- R3: When a read index equals `wr_idx` and the write is accepted in that cycle, the read port returns `wr_data` before the edge.
- R4: Index 13 reaches the process stack pointer when `stk_proc_o`=1 and the main stack pointer when it is 0. The other copy is untouched. A special write with `spec_sel`=2 loads `stk_proc_o` from `spec_wdata[0]`.
- R5: `pc_op` encodes 0 hold, 1 step, 2 branch, 3 call and 4 return; codes 5..7 hold. A step adds 4 when `pc_wide`=1 and 2 when it is 0.
- R6: A branch loads the PC with `pc_target` with bit 0 forced to 0.
- R7: A call loads the PC with the aligned target and the link register with the address of the next sequential instruction (PC plus step size) on the same edge. A write-port write to index 14 in that cycle is lost.
- R8: A return loads the PC with the link register value, bit 0 forced to 0.
- R9: `flag_we`=1 loads `flag_nzcv` (N,Z,C,V from MSB to LSB) into `psr_o[31:28]`. This takes priority over a status-word write in the same cycle. With neither, the flags hold.
- R10: A special write with `spec_sel`=0 changes only `psr_o[31:28]`. `psr_o[5:0]` always follows `exc_num`, `psr_o[24]` always reads 1, and all other bits read 0.
- R11: A special write with `spec_sel`=1 loads the mask bit from `spec_wdata[0]`. While it is 1, `irq_gated` bits 2 and up are 0. Bit 0 (non-maskable) and bit 1 (hard fault) always pass `irq_req` through.
- R12: With `wr_restrict`=1, a write to index 8..12 raises `wr_err` in the same cycle, leaves the register unchanged and is not bypassed. Writes to indices 0..7 are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_rst_val | input | 32 | PC value loaded at reset |
| msp_rst_val | input | 32 | Main stack pointer value loaded at reset |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| wr_restrict | input | 1 | Reject writes to indices 8..12 |
| wr_err | output | 1 | Rejected write in this cycle |
| pc_op | input | 3 | PC sequencing operation |
| pc_wide | input | 1 | Current instruction is 32-bit (step 4) |
| pc_target | input | 32 | Branch or call target |
| pc_o | output | 32 | Program counter |
| flag_we | input | 1 | ALU flag update enable |
| flag_nzcv | input | 4 | New N,Z,C,V flags |
| spec_we | input | 1 | Special register write enable |
| spec_sel | input | 2 | 0 status word, 1 mask, 2 stack select |
| spec_wdata | input | 32 | Special register write data |
| exc_num | input | 6 | Active exception number |
| psr_o | output | 32 | Status word |
| mask_o | output | 1 | Interrupt mask bit |
| stk_proc_o | output | 1 | Process stack pointer selected |
| irq_req | input | 8 | Requests: bit 0 non-maskable, bit 1 hard fault, rest maskable |
| irq_gated | output | 8 | Gated request vector |

## Verification
The bench targets the places where two sources compete for one register. A call that coincides with a write to the link register must keep the return address; a design with the wrong priority returns to the written value. A rejected high-register write must neither land nor bypass; a design that bypasses before checking shows the rejected data on the read port. A flag update coinciding with a status-word write must win; a design that gets this wrong shows the written flags. The bench also switches the stack selection back and forth and confirms each copy keeps its value, which catches a single shared pointer. It sends odd branch and link values to catch a PC that keeps bit 0. It writes all-ones to the status word to expose a writable exception-number or state field.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [2:0] {
        PC_HOLD   = 3'd0,
        PC_STEP   = 3'd1,
        PC_BRANCH = 3'd2,
        PC_CALL   = 3'd3,
        PC_RETURN = 3'd4
    } pc_op_e;

    typedef enum logic [1:0] {
        SEL_PSR  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } spec_sel_e;

    typedef enum logic {
        STK_MAIN = 1'b0,
        STK_PROC = 1'b1
    } stk_state_e;

    localparam int IDX_SP   = 13;
    localparam int IDX_LR   = 14;
    localparam int IDX_PC   = 15;
    localparam int NUM_GP   = 13;
    localparam int HIGH_LO  = 8;
    localparam int HIGH_HI  = 12;
    localparam int PSR_FLAG_LSB = 28;
    localparam int PSR_T    = 24;
    localparam int NUM_NMASK = 2;

endpackage

// File: rtl/rb_gpr_file.sv
module rb_gpr_file
    import regbank_pkg::*;
#(
    parameter int DW  = 32,
    parameter int IW  = 4,
    parameter int NGP = NUM_GP,
    parameter int NRD = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       msp_rst_val,
    input  logic                stk_proc,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic                link_we,
    input  logic [DW-1:0]       link_data,
    input  logic [NRD*IW-1:0]   rd_idx,
    output logic [NRD*DW-1:0]   rd_raw,
    output logic [DW-1:0]       lr_q
);

    logic [DW-1:0] gp_q [NGP];
    logic [DW-1:0] msp_q;
    logic [DW-1:0] psp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NGP; g++) begin
                gp_q[g] <= '0;
            end
        end else if (wr_en) begin
            for (int g = 0; g < NGP; g++) begin
                if (wr_idx == IW'(g)) begin
                    gp_q[g] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msp_q <= msp_rst_val;
            psp_q <= '0;
        end else if (wr_en && wr_idx == IW'(IDX_SP)) begin
            if (stk_proc) begin
                psp_q <= wr_data;
            end else begin
                msp_q <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q <= '0;
        end else if (link_we) begin
            lr_q <= link_data;
        end else if (wr_en && wr_idx == IW'(IDX_LR)) begin
            lr_q <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [IW-1:0] idx;
        assign idx = rd_idx[p*IW +: IW];
        always_comb begin
            if (int'(idx) < NGP) begin
                rd_raw[p*DW +: DW] = gp_q[idx];
            end else if (idx == IW'(IDX_SP)) begin
                rd_raw[p*DW +: DW] = stk_proc ? psp_q : msp_q;
            end else if (idx == IW'(IDX_LR)) begin
                rd_raw[p*DW +: DW] = lr_q;
            end else begin
                rd_raw[p*DW +: DW] = '0;
            end
        end
    end

endmodule

// File: rtl/rb_pc_seq.sv
module rb_pc_seq
    import regbank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pc_rst_val,
    input  logic [2:0]    op_raw,
    input  logic          wide,
    input  logic [DW-1:0] target,
    input  logic [DW-1:0] lr_q,
    output logic [DW-1:0] pc_q,
    output logic          link_we,
    output logic [DW-1:0] link_data
);

    pc_op_e        op;
    logic [DW-1:0] seq_next;
    logic [DW-1:0] pc_next;

    assign op        = pc_op_e'(op_raw);
    assign seq_next  = pc_q + (wide ? DW'(4) : DW'(2));
    assign link_we   = (op == PC_CALL);
    assign link_data = seq_next;

    always_comb begin
        unique case (op)
            PC_STEP:   pc_next = seq_next;
            PC_BRANCH,
            PC_CALL:   pc_next = {target[DW-1:1], 1'b0};
            PC_RETURN: pc_next = {lr_q[DW-1:1], 1'b0};
            default:   pc_next = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= {pc_rst_val[DW-1:1], 1'b0};
        end else begin
            pc_q <= pc_next;
        end
    end

endmodule

// File: rtl/rb_status.sv
module rb_status
    import regbank_pkg::*;
#(
    parameter int DW    = 32,
    parameter int EXC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_we,
    input  logic [3:0]       flag_nzcv,
    input  logic             spec_we,
    input  logic [1:0]       spec_sel,
    input  logic [3:0]       wr_flags,
    input  logic             wr_bit0,
    input  logic [EXC_W-1:0] exc_num,
    output logic [DW-1:0]    psr,
    output logic             mask,
    output logic             stk_proc
);

    spec_sel_e  sel;
    stk_state_e stk_state;
    stk_state_e stk_next;
    logic [3:0] flags_q;
    logic       ctrl_wr;

    assign sel     = spec_sel_e'(spec_sel);
    assign ctrl_wr = spec_we && (sel == SEL_CTRL);

    always_comb begin
        stk_next = stk_state;
        unique case (stk_state)
            STK_MAIN: if (ctrl_wr && wr_bit0)  stk_next = STK_PROC;
            STK_PROC: if (ctrl_wr && !wr_bit0) stk_next = STK_MAIN;
            default:  stk_next = STK_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_state <= STK_MAIN;
        end else begin
            stk_state <= stk_next;
        end
    end

    always_comb begin
        stk_proc = (stk_state == STK_PROC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (flag_we) begin
            flags_q <= flag_nzcv;
        end else if (spec_we && sel == SEL_PSR) begin
            flags_q <= wr_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= 1'b0;
        end else if (spec_we && sel == SEL_MASK) begin
            mask <= wr_bit0;
        end
    end

    always_comb begin
        psr                             = '0;
        psr[PSR_FLAG_LSB +: 4]          = flags_q;
        psr[PSR_T]                      = 1'b1;
        psr[EXC_W-1:0]                  = exc_num;
    end

endmodule

// File: rtl/rb_irq_gate.sv
module rb_irq_gate
    import regbank_pkg::*;
#(
    parameter int NREQ = 8
) (
    input  logic            mask,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gated
);

    for (genvar i = 0; i < NREQ; i++) begin : g_line
        if (i < NUM_NMASK) begin : g_pass
            assign gated[i] = req[i];
        end else begin : g_mask
            assign gated[i] = req[i] & ~mask;
        end
    end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import regbank_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREQ  = 8,
    parameter int EXC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    pc_rst_val,
    input  logic [DW-1:0]    msp_rst_val,
    input  logic [3:0]       rd_a_idx,
    output logic [DW-1:0]    rd_a_data,
    input  logic [3:0]       rd_b_idx,
    output logic [DW-1:0]    rd_b_data,
    input  logic             wr_en,
    input  logic [3:0]       wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_restrict,
    output logic             wr_err,
    input  logic [2:0]       pc_op,
    input  logic             pc_wide,
    input  logic [DW-1:0]    pc_target,
    output logic [DW-1:0]    pc_o,
    input  logic             flag_we,
    input  logic [3:0]       flag_nzcv,
    input  logic             spec_we,
    input  logic [1:0]       spec_sel,
    input  logic [DW-1:0]    spec_wdata,
    input  logic [EXC_W-1:0] exc_num,
    output logic [DW-1:0]    psr_o,
    output logic             mask_o,
    output logic             stk_proc_o,
    input  logic [NREQ-1:0]  irq_req,
    output logic [NREQ-1:0]  irq_gated
);

    localparam int IW  = 4;
    localparam int NRD = 2;

    logic              wr_high;
    logic              wr_ok;
    logic              link_we;
    logic [DW-1:0]     link_data;
    logic [DW-1:0]     lr_q;
    logic [DW-1:0]     pc_q;
    logic [NRD*IW-1:0] rd_idx;
    logic [NRD*DW-1:0] rd_raw;
    logic [NRD*DW-1:0] rd_out;

    assign wr_high = (int'(wr_idx) >= HIGH_LO) && (int'(wr_idx) <= HIGH_HI);
    assign wr_err  = wr_en && wr_restrict && wr_high;
    assign wr_ok   = wr_en && !wr_err && (wr_idx != IW'(IDX_PC)) &&
                     !(link_we && wr_idx == IW'(IDX_LR));

    assign rd_idx  = {rd_b_idx, rd_a_idx};

    rb_pc_seq #(.DW(DW)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_rst_val (pc_rst_val),
        .op_raw     (pc_op),
        .wide       (pc_wide),
        .target     (pc_target),
        .lr_q       (lr_q),
        .pc_q       (pc_q),
        .link_we    (link_we),
        .link_data  (link_data)
    );

    rb_gpr_file #(.DW(DW), .IW(IW), .NGP(NUM_GP), .NRD(NRD)) u_gpr (
        .clk         (clk),
        .rst_n       (rst_n),
        .msp_rst_val (msp_rst_val),
        .stk_proc    (stk_proc_o),
        .wr_en       (wr_ok),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .link_we     (link_we),
        .link_data   (link_data),
        .rd_idx      (rd_idx),
        .rd_raw      (rd_raw),
        .lr_q        (lr_q)
    );

    rb_status #(.DW(DW), .EXC_W(EXC_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_we   (flag_we),
        .flag_nzcv (flag_nzcv),
        .spec_we   (spec_we),
        .spec_sel  (spec_sel),
        .wr_flags  (spec_wdata[PSR_FLAG_LSB +: 4]),
        .wr_bit0   (spec_wdata[0]),
        .exc_num   (exc_num),
        .psr       (psr_o),
        .mask      (mask_o),
        .stk_proc  (stk_proc_o)
    );

    rb_irq_gate #(.NREQ(NREQ)) u_irq (
        .mask  (mask_o),
        .req   (irq_req),
        .gated (irq_gated)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        logic [IW-1:0] idx;
        assign idx = rd_idx[p*IW +: IW];
        always_comb begin
            if (idx == IW'(IDX_PC)) begin
                rd_out[p*DW +: DW] = pc_q;
            end else if (wr_ok && idx == wr_idx) begin
                rd_out[p*DW +: DW] = wr_data;
            end else begin
                rd_out[p*DW +: DW] = rd_raw[p*DW +: DW];
            end
        end
    end

    assign rd_a_data = rd_out[0 +: DW];
    assign rd_b_data = rd_out[DW +: DW];
    assign pc_o      = pc_q;

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int DW   = 32,
    parameter int NREQ = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      pc_op,
    input logic            pc_wide,
    input logic [DW-1:0]   pc_target,
    input logic [DW-1:0]   pc_o,
    input logic [DW-1:0]   lr_q,
    input logic            flag_we,
    input logic            spec_we,
    input logic [1:0]      spec_sel,
    input logic [DW-1:0]   psr_o,
    input logic            mask_o,
    input logic [NREQ-1:0] irq_req,
    input logic [NREQ-1:0] irq_gated
);

    // R5: a step moves the PC by the selected instruction size
    p_step_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_op == 3'd1 |=> pc_o == $past(pc_o) + ($past(pc_wide) ? DW'(4) : DW'(2)));

    // R7: a call saves the sequential address and takes the aligned target
    p_call_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_op == 3'd3 |=> (lr_q == $past(pc_o) + ($past(pc_wide) ? DW'(4) : DW'(2)))
                          && (pc_o == {$past(pc_target[DW-1:1]), 1'b0}));

    // R8: a return reloads the PC from the link register
    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_op == 3'd4 |=> pc_o == {$past(lr_q[DW-1:1]), 1'b0});

    // R9: flags hold without an update source
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && !(spec_we && spec_sel == 2'd0)) |=> $stable(psr_o[DW-1:DW-4]));

    // R11: the mask silences every maskable line
    p_mask_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o |-> irq_gated[NREQ-1:2] == '0);

    // R11: the two non-maskable lines always pass
    p_nmask_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_gated[1:0] == irq_req[1:0]);

endmodule

bind cpu_regbank rb_checker #(.DW(DW), .NREQ(NREQ)) u_rb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_op     (pc_op),
    .pc_wide   (pc_wide),
    .pc_target (pc_target),
    .pc_o      (pc_o),
    .lr_q      (lr_q),
    .flag_we   (flag_we),
    .spec_we   (spec_we),
    .spec_sel  (spec_sel),
    .psr_o     (psr_o),
    .mask_o    (mask_o),
    .irq_req   (irq_req),
    .irq_gated (irq_gated)
);

// File: tb/cpu_regbank_bench.sv
module cpu_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_rst_val = 32'h0000_1001;
    logic [31:0] msp_rst_val = 32'h2000_0400;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_restrict = 1'b0;
    logic        wr_err;
    logic [2:0]  pc_op = '0;
    logic        pc_wide = 1'b0;
    logic [31:0] pc_target = '0;
    logic [31:0] pc_o;
    logic        flag_we = 1'b0;
    logic [3:0]  flag_nzcv = '0;
    logic        spec_we = 1'b0;
    logic [1:0]  spec_sel = 2'd3;
    logic [31:0] spec_wdata = '0;
    logic [5:0]  exc_num = '0;
    logic [31:0] psr_o;
    logic        mask_o, stk_proc_o;
    logic [7:0]  irq_req = '0, irq_gated;

    int total = 0;
    int failed = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cpu_regbank u_cpu_regbank (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_restrict = 0; pc_op = 3'd0; flag_we = 0; spec_we = 0; spec_sel = 2'd3;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d);
        wr_en = 1; wr_idx = i; wr_data = d;
        tick();
    endtask

    task automatic spec(input logic [1:0] s, input logic [31:0] d);
        spec_we = 1; spec_sel = s; spec_wdata = d;
        tick();
    endtask

    task automatic rd_a(input logic [3:0] i, input string req, input logic [31:0] exp);
        rd_a_idx = i; #1;
        chk(req, rd_a_data, exp);
    endtask

    function automatic logic [31:0] psr_exp(input logic [3:0] f, input logic [5:0] e);
        return {f, 3'b000, 1'b1, 18'd0, e};
    endfunction

    task automatic t_reset();
        #1;
        chk("R1 pc in reset", pc_o, 32'h0000_1000);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pc", pc_o, 32'h0000_1000);
        rd_a(4'd13, "R1 msp", 32'h2000_0400);
        rd_b_idx = 4'd3; #1;
        chk("R1 r3 zero", rd_b_data, 32'h0);
        chk("R1 psr", psr_o, psr_exp(4'h0, 6'h0));
        chk("R1 mask/stk", {30'd0, mask_o, stk_proc_o}, 32'h0);
    endtask

    task automatic t_gpr();
        wr(4'd0, 32'hA5A5_0001);
        wr(4'd7, 32'hA5A5_0007);
        wr(4'd12, 32'hA5A5_000C);
        wr(4'd14, 32'hA5A5_000E);
        rd_a(4'd0, "R2 r0", 32'hA5A5_0001);
        rd_b_idx = 4'd12; #1;
        chk("R2 r12 port b", rd_b_data, 32'hA5A5_000C);
        rd_a(4'd7, "R2 r7", 32'hA5A5_0007);
        rd_a(4'd14, "R2 r14", 32'hA5A5_000E);
    endtask

    task automatic t_bypass();
        wr_en = 1; wr_idx = 4'd5; wr_data = 32'hDEAD_BEEF;
        rd_a_idx = 4'd5; rd_b_idx = 4'd0; #1;
        chk("R3 bypass", rd_a_data, 32'hDEAD_BEEF);
        chk("R3 other port", rd_b_data, 32'hA5A5_0001);
        tick();
        rd_a(4'd5, "R3 after edge", 32'hDEAD_BEEF);
    endtask

    task automatic t_r15();
        wr_en = 1; wr_idx = 4'd15; wr_data = 32'h5555_0000;
        rd_a_idx = 4'd15; #1;
        chk("R2 r15 no bypass", rd_a_data, 32'h0000_1000);
        tick();
        chk("R2 r15 write ignored", pc_o, 32'h0000_1000);
    endtask

    task automatic t_sp_bank();
        wr(4'd13, 32'h1111_0000);
        spec(2'd2, 32'h1);
        chk("R4 stk_proc set", {31'd0, stk_proc_o}, 32'h1);
        rd_a(4'd13, "R4 psp initial", 32'h0);
        wr(4'd13, 32'h2222_0000);
        rd_a(4'd13, "R4 psp written", 32'h2222_0000);
        spec(2'd2, 32'h0);
        chk("R4 stk_proc clear", {31'd0, stk_proc_o}, 32'h0);
        rd_a(4'd13, "R4 msp kept", 32'h1111_0000);
        spec(2'd2, 32'h1);
        rd_a(4'd13, "R4 psp kept", 32'h2222_0000);
        spec(2'd2, 32'h0);
    endtask

    task automatic t_pc();
        pc_op = 3'd1; pc_wide = 1; tick();
        chk("R5 step 4", pc_o, 32'h0000_1004);
        pc_op = 3'd1; pc_wide = 0; tick();
        chk("R5 step 2", pc_o, 32'h0000_1006);
        pc_op = 3'd0; tick();
        chk("R5 hold", pc_o, 32'h0000_1006);
        pc_op = 3'd2; pc_target = 32'h0000_3001; tick();
        chk("R6 branch aligned", pc_o, 32'h0000_3000);
        pc_op = 3'd7; pc_target = 32'h0000_7000; tick();
        chk("R5 undefined holds", pc_o, 32'h0000_3000);
    endtask

    task automatic t_call_ret();
        pc_op = 3'd3; pc_wide = 1; pc_target = 32'h0000_4000;
        wr_en = 1; wr_idx = 4'd14; wr_data = 32'h9999_9999;
        tick();
        chk("R7 call target", pc_o, 32'h0000_4000);
        rd_a(4'd14, "R7 link beats write", 32'h0000_3004);
        pc_op = 3'd1; pc_wide = 0; tick();
        chk("R5 step in callee", pc_o, 32'h0000_4002);
        pc_op = 3'd4; tick();
        chk("R8 return", pc_o, 32'h0000_3004);
        wr(4'd14, 32'h0000_5003);
        pc_op = 3'd4; tick();
        chk("R8 return aligned", pc_o, 32'h0000_5002);
    endtask

    task automatic t_flags();
        exc_num = 6'h2B;
        flag_we = 1; flag_nzcv = 4'b1010; tick();
        chk("R9 flags", psr_o, psr_exp(4'hA, 6'h2B));
        spec(2'd0, 32'hFFFF_FFFF);
        chk("R10 psr write", psr_o, psr_exp(4'hF, 6'h2B));
        flag_we = 1; flag_nzcv = 4'b0101;
        spec(2'd0, 32'hFFFF_FFFF);
        chk("R9 flag priority", psr_o, psr_exp(4'h5, 6'h2B));
        tick();
        chk("R9 flags hold", psr_o, psr_exp(4'h5, 6'h2B));
        exc_num = 6'h11; #1;
        chk("R10 exc follows input", psr_o, psr_exp(4'h5, 6'h11));
    endtask

    task automatic t_mask();
        irq_req = 8'hFF; #1;
        chk("R11 unmasked", {24'd0, irq_gated}, 32'hFF);
        spec(2'd1, 32'h1);
        chk("R11 masked", {24'd0, irq_gated}, 32'h03);
        irq_req = 8'h81; #1;
        chk("R11 masked nmi only", {24'd0, irq_gated}, 32'h01);
        spec(2'd1, 32'h0);
        chk("R11 unmasked again", {24'd0, irq_gated}, 32'h81);
    endtask

    task automatic t_restrict();
        wr_en = 1; wr_restrict = 1; wr_idx = 4'd9; wr_data = 32'h7777_0000;
        rd_a_idx = 4'd9; #1;
        chk("R12 err raised", {31'd0, wr_err}, 32'h1);
        chk("R12 no bypass", rd_a_data, 32'h0);
        tick();
        rd_a(4'd9, "R12 r9 unchanged", 32'h0);
        wr_en = 1; wr_restrict = 1; wr_idx = 4'd3; wr_data = 32'h3333_0000; #1;
        chk("R12 low no err", {31'd0, wr_err}, 32'h0);
        tick();
        rd_a(4'd3, "R12 low written", 32'h3333_0000);
        wr(4'd9, 32'h7777_0000);
        rd_a(4'd9, "R12 unrestricted high", 32'h7777_0000);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_gpr();
        t_bypass();
        t_r15();
        t_sp_bank();
        t_pc();
        t_call_ret();
        t_flags();
        t_mask();
        t_restrict();
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule